// File: doc/BRIEF.md
# Multi-Channel Counter PWM Generator

This block produces several independent pulse-width-modulated outputs from one clock. Each channel owns a tick counter, a period length setting, a high-time setting and an on/off control bit. Software-side logic writes these through a single write strobe with a channel-and-register address. A per-channel tick-enable input lets the counters run at a slower rate than the clock.

Period and high-time writes go into shadow registers. They are copied into the active registers only when the running period wraps, so a waveform is never cut short mid-period. The two settings reload independently of each other. Clearing the control bit is the exception: it stops the output on the very next clock. Setting the bit restarts the counter from zero and loads the shadow values at once.

Top module: `pwm_multi`

## Requirements
- R1: With an active period setting of x, one period lasts exactly x+1 ticks: the counter counts 0..x and then wraps to 0.
- R2: An enabled channel drives its output high while its counter is strictly below the active high-time value. A high-time of 0 gives a constant low output.
- R3: A high-time value greater than the period setting keeps the output high for every tick of the period (100% duty).
- R4: A write to the period or high-time register does not alter the running period. The new value becomes active at the first period wrap after the write.
- R5: The period and high-time registers reload on their own. If the period is written before a wrap and the high-time just after it, exactly one period runs with the new period and the old high-time.
- R6: Writing 0 to the control bit forces the output low on the next clock, whatever the counter position. The counter is then held at 0 while the channel is disabled.
- R7: Writing 1 to the control bit of a disabled channel restarts its counter at 0 and loads both shadow values into the active registers in the same clock.
- R8: An enabled counter advances only on clocks where that channel's tick_en bit is 1.
- R9: After reset, all registers are 0, every channel is disabled and every output is low.
- R10: Write address layout: wr_addr = {channel, select}, where select is the low 2 bits. Select 0 is the period register, select 1 is the high-time register, and select 2 is control (wr_data bit 0 = enable). Select 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | CH_W+2 | Channel index (upper bits) and register select (low 2 bits) |
| wr_data | input | CNT_W | Write data |
| tick_en | input | NUM_CH | Per-channel counter advance enable |
| pwm_out | output | NUM_CH | PWM outputs |

## Verification
The collision that matters is a shadow-register write arriving around the period wrap, when the active registers reload.

The bench provokes it in two ways:
- It writes the high-time mid-period, then confirms that the current period keeps the old high time and the next one uses the new value.
- It writes the period before a wrap and the high-time right after it. The sampled waveform must then show one period mixing the new length with the old high time, followed by a period using both new values.

Every period is judged tick by tick against a pattern computed from the period and high-time settings.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int SEL_W      = 2;
    localparam int CTRL_EN_BIT = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_PERIOD = 2'd0,
        SEL_HIGH   = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ld_period;
        logic ld_high;
        logic ld_ctrl;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_sel(input logic hit, input reg_sel_e sel);
        wr_strobe_t s;
        s.ld_period = hit && (sel == SEL_PERIOD);
        s.ld_high   = hit && (sel == SEL_HIGH);
        s.ld_ctrl   = hit && (sel == SEL_CTRL);
        return s;
    endfunction

endpackage

// File: rtl/pwm_wr_decode.sv
module pwm_wr_decode
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                        wr_en,
    input  logic [CH_W+SEL_W-1:0]       wr_addr,
    output wr_strobe_t [NUM_CH-1:0]     strb
);
    localparam int ADDR_W = CH_W + SEL_W;

    logic [CH_W-1:0] ch_idx;
    reg_sel_e        sel;

    assign ch_idx = wr_addr[ADDR_W-1:SEL_W];
    assign sel    = reg_sel_e'(wr_addr[SEL_W-1:0]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign strb[g] = decode_sel(wr_en && (ch_idx == CH_W'(g)), sel);
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       strb,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick,
    output logic             pwm_out
);
    logic [CNT_W-1:0] per_sh, high_sh;
    logic [CNT_W-1:0] per_act, high_act;
    logic [CNT_W-1:0] cnt;
    logic             en_q;
    logic             wrap;
    logic             turn_on, turn_off;

    assign wrap     = en_q && tick && (cnt == per_act);
    assign turn_on  = strb.ld_ctrl && wr_data[CTRL_EN_BIT] && !en_q;
    assign turn_off = strb.ld_ctrl && !wr_data[CTRL_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            per_sh   <= '0;
            high_sh  <= '0;
            per_act  <= '0;
            high_act <= '0;
            cnt      <= '0;
            en_q     <= 1'b0;
        end else begin
            if (strb.ld_period) per_sh  <= wr_data;
            if (strb.ld_high)   high_sh <= wr_data;
            if (strb.ld_ctrl)   en_q    <= wr_data[CTRL_EN_BIT];

            if (turn_off) begin
                cnt <= '0;
            end else if (turn_on) begin
                cnt      <= '0;
                per_act  <= per_sh;
                high_act <= high_sh;
            end else if (wrap) begin
                cnt      <= '0;
                per_act  <= per_sh;
                high_act <= high_sh;
            end else if (en_q && tick) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign pwm_out = en_q && (cnt < high_act);

    // R1: counter never passes the active period setting
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        en_q |-> cnt <= per_act);

    // R3: high-time above period means the output stays high
    a_r3_full_high: assert property (@(posedge clk) disable iff (rst)
        (en_q && high_act > per_act) |-> pwm_out);

    // R4: active values only change at a wrap or on enable
    a_r4_no_midperiod_load: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q) && $past(cnt) != $past(per_act))
            |-> ($stable(per_act) && $stable(high_act)));

    // R6: disabling forces a low output and a cleared counter
    a_r6_stop_now: assert property (@(posedge clk) disable iff (rst)
        $fell(en_q) |-> (cnt == '0 && !pwm_out));

    // R7: enabling restarts and loads shadows at once
    a_r7_start_load: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> (cnt == '0 && per_act == $past(per_sh) && high_act == $past(high_sh)));

    // R8: without a tick the counter holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q) && !$past(tick)) |-> $stable(cnt));
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CH_W+SEL_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [NUM_CH-1:0]     tick_en,
    output logic [NUM_CH-1:0]     pwm_out
);
    wr_strobe_t [NUM_CH-1:0] strb;

    pwm_wr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .strb    (strb)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .strb    (strb[g]),
            .wr_data (wr_data),
            .tick    (tick_en[g]),
            .pwm_out (pwm_out[g])
        );
    end

    // R9: outputs low in the cycle after reset
    a_r9_reset_low: assert property (@(posedge clk)
        $past(rst) |-> pwm_out == '0);
endmodule

// File: tb/test_pwm_multi.sv
module test_pwm_multi;
    localparam int NUM_CH = 4;
    localparam int CNT_W  = 8;
    localparam int AW     = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [CNT_W-1:0]  wr_data;
    logic [NUM_CH-1:0] tick_en;
    logic [NUM_CH-1:0] pwm_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    bit  smp [0:63];

    always #10 clk = ~clk;

    pwm_multi #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_pwm_multi (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_en(tick_en), .pwm_out(pwm_out)
    );

    // period setting, high-time setting, expected period, expected high ticks
    localparam int NV = 7;
    localparam int VEC [NV][4] = '{
        '{9, 3, 10, 3},
        '{4, 0, 5, 0},
        '{7, 8, 8, 8},
        '{7, 20, 8, 8},
        '{0, 1, 1, 1},
        '{0, 0, 1, 0},
        '{15, 15, 16, 15}
    };

    // R10: select 0 period, 1 high-time, 2 control
    task automatic wr(input int ch, input int sel, input int d);
        wr_en   = 1'b1;
        wr_addr = {2'(ch), 2'(sel)};
        wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic setup(input int ch, input int per, input int hi);
        wr(ch, 2, 0);
        wr(ch, 0, per);
        wr(ch, 1, hi);
        wr(ch, 2, 1);
    endtask

    task automatic cap(input int ch, input int n, input bit slow,
                       input int at1, input int s1, input int d1,
                       input int at2, input int s2, input int d2);
        for (int i = 0; i < n; i++) begin
            smp[i] = pwm_out[ch];
            wr_en  = 1'b0;
            if (i == at1) begin wr_en = 1'b1; wr_addr = {2'(ch), 2'(s1)}; wr_data = CNT_W'(d1); end
            if (i == at2) begin wr_en = 1'b1; wr_addr = {2'(ch), 2'(s2)}; wr_data = CNT_W'(d2); end
            tick_en[ch] = slow ? (i % 2 == 1) : 1'b1;
            @(negedge clk);
        end
        wr_en = 1'b0;
        tick_en = '1;
    endtask

    task automatic seg(input string tag, input int lo, input int n, input int exp_hi);
        int mism = 0;
        int act  = 0;
        for (int i = 0; i < n; i++) begin
            if (smp[lo+i]) act++;
            if (smp[lo+i] != (i < exp_hi)) mism++;
        end
        checks++;
        if (mism != 0) begin
            errors++;
            $display("FAIL %s: window %0d..%0d high=%0d mismatches=%0d expected high=%0d of %0d",
                     tag, lo, lo+n-1, act, mism, exp_hi, n);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; tick_en = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: outputs low after reset
        checks++;
        if (pwm_out !== '0) begin
            errors++;
            $display("FAIL R9: pwm_out=%b expected=0000", pwm_out);
        end

        // R9: enabling with reset-valued registers gives a low output
        wr(3, 2, 1);
        cap(3, 6, 0, -1, 0, 0, -1, 0, 0);
        seg("R9 reset-valued channel", 0, 6, 0);
        wr(3, 2, 0);

        // R1 R2 R3 R10: table of settings, two periods each
        for (int v = 0; v < NV; v++) begin
            setup(0, VEC[v][0], VEC[v][1]);
            cap(0, 2*VEC[v][2], 0, -1, 0, 0, -1, 0, 0);
            seg($sformatf("R1/R2/R3 vec%0d period0", v), 0, VEC[v][2], VEC[v][3]);
            seg($sformatf("R1/R2/R3 vec%0d period1", v), VEC[v][2], VEC[v][2], VEC[v][3]);
        end

        // R4: high-time written mid-period waits for the wrap
        setup(0, 9, 3);
        cap(0, 20, 0, 4, 1, 6, -1, 0, 0);
        seg("R4 old high-time kept", 0, 10, 3);
        seg("R4 new high-time at wrap", 10, 10, 6);

        // R5: period before the wrap, high-time after it
        setup(0, 9, 3);
        cap(0, 25, 0, 5, 0, 4, 10, 1, 7);
        seg("R5 first period", 0, 10, 3);
        seg("R5 mixed period", 10, 5, 3);
        seg("R5 both new", 15, 5, 5);
        seg("R5 both new again", 20, 5, 5);

        // R6: disable while high stops on the next clock
        setup(0, 9, 3);
        cap(0, 6, 0, 1, 2, 0, 3, 0, 3);
        seg("R6 immediate stop", 0, 6, 2);

        // R7: re-enable loads values written while disabled
        wr(0, 1, 2);
        wr(0, 2, 1);
        cap(0, 8, 0, -1, 0, 0, -1, 0, 0);
        seg("R7 restart period0", 0, 4, 2);
        seg("R7 restart period1", 4, 4, 2);

        // R8: counter advances only on tick clocks
        setup(1, 2, 1);
        cap(1, 12, 1, -1, 0, 0, -1, 0, 0);
        seg("R8 slow tick period0", 0, 6, 2);
        seg("R8 slow tick period1", 6, 6, 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule